// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is a single capture channel for a timer. An asynchronous input pin is brought into the clock domain by a two-stage synchroniser. A programmable noise filter then rejects short pulses, and an edge selector picks which transitions of the cleaned level count as events. On each selected event, the free-running counter value supplied by the surrounding timer is latched into a capture register. A capture flag is set and a one-cycle request pulse is raised for an interrupt or DMA engine.

Software, or a DMA engine, takes the captured value and signals this with a read strobe, which clears the flag. If a second capture lands while the flag is still set and no read is consuming it, a sticky overcapture flag records the lost value. When both edges are selected, subtracting consecutive captures gives the high or low time of a pulse in counter ticks.

Top module: `icap_channel`

## Requirements
- R1: While `rst` is high at a clock edge, `cap_val_o`, `cap_flag_o`, `ovr_flag_o` and `req_o` all become 0 after that edge. The filtered level and the edge history also restart at 0.
- R2: Let a pin level first be sampled at edge k, and let the filter setting be N. The capture takes place at edge k+2+max(N,1), and `req_o` is high in the cycle after that edge. Settings 0 and 1 therefore give the same latency.
- R3: The filtered level adopts a new value only after the synchronised input has differed from it on max(N,1) consecutive samples. A pulse shorter than that produces no capture.
- R4: `edge_sel_i` selects the events as follows: 2'b00 rising edges only, 2'b01 falling edges only, 2'b10 both edges, 2'b11 none. With 2'b11, pin activity leaves every output unchanged.
- R5: On a capture, `cap_val_o` takes the value that `cnt_i` held at the capturing edge. It holds that value until the next capture.
- R6: `req_o` is high for exactly one cycle per capture.
- R7: A capture sets `cap_flag_o`. `rd_i` clears it, unless a capture happens in the same cycle, in which case the flag stays set.
- R8: A capture while `cap_flag_o` is set and `rd_i` is low sets `ovr_flag_o`. The flag stays set until `ovr_clr_i` is asserted, and a new overcapture in that same cycle takes priority over the clear.
- R9: With both edges selected, the difference between the rising and falling captures of a pulse equals the pulse's high time measured in `cnt_i` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous channel input |
| cnt_i | input | CNT_W | Running counter value to capture |
| filt_len_i | input | FLT_W | Filter setting N (0 or 1 means one sample) |
| edge_sel_i | input | 2 | Edge selection (see R4) |
| rd_i | input | 1 | Capture value consumed; clears capture flag |
| ovr_clr_i | input | 1 | Clears the overcapture flag |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Capture pending |
| ovr_flag_o | output | 1 | A capture was overwritten before being read |
| req_o | output | 1 | One-cycle capture request pulse |

## Verification
The in-line assertions check several properties on every cycle. The filtered level never changes while the synchronised input already agrees with it, and a change always moves toward that input. A detected edge always coincides with a change in the filtered level. The captured value only moves on a request, and a request always leaves the capture flag set. A read without a competing capture clears the flag, and the overcapture flag stays set until it is cleared. Other behaviour depends on timing across many cycles and only the bench scenarios can show it. This covers the exact capture latency for different filter settings, the rejection of glitches just shorter than the filter window, and the pulse-width difference between the two captures.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din_i,
  input  logic [FLT_W-1:0] len_i,
  output logic             level_o
);
  logic [FLT_W-1:0] run_q;
  logic [FLT_W-1:0] last_run;

  // a setting of 0 behaves as 1: accept on the first differing sample
  always_comb begin
    if (len_i == '0) last_run = '0;
    else             last_run = len_i - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b0;
      run_q   <= '0;
    end else if (din_i == level_o) begin
      run_q <= '0;
    end else if (run_q >= last_run) begin
      level_o <= din_i;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_FILT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (din_i == level_o) |=> $stable(level_o)); // R3
  AST_FILT_TOWARD: assert property (@(posedge clk) disable iff (rst)
    (level_o != $past(level_o)) |-> ($past(din_i) == level_o)); // R3
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_i,
  input  edge_mode_e mode_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (lvl_i != prev_q)); // R4
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FLT_W     = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [FLT_W-1:0] filt_len_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             rd_i,
  input  logic             ovr_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o,
  output logic             req_o
);
  logic       pin_s;
  logic       pin_f;
  logic       hit;
  edge_mode_e mode;

  assign mode = edge_mode_e'(edge_sel_i);

  icap_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk (clk), .rst (rst), .d_i (pin_i), .q_o (pin_s)
  );

  icap_filter #(.FLT_W(FLT_W)) u_filt (
    .clk (clk), .rst (rst), .din_i (pin_s), .len_i (filt_len_i), .level_o (pin_f)
  );

  icap_edge u_edge (
    .clk (clk), .rst (rst), .lvl_i (pin_f), .mode_i (mode), .hit_o (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val_o  <= '0;
      cap_flag_o <= 1'b0;
      ovr_flag_o <= 1'b0;
      req_o      <= 1'b0;
    end else begin
      req_o <= hit;
      if (hit) cap_val_o <= cnt_i;
      if (hit)       cap_flag_o <= 1'b1;
      else if (rd_i) cap_flag_o <= 1'b0;
      if (hit && cap_flag_o && !rd_i) ovr_flag_o <= 1'b1;
      else if (ovr_clr_i)             ovr_flag_o <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_o |-> $stable(cap_val_o)); // R5
  AST_REQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    req_o |-> cap_flag_o); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !hit) |=> !cap_flag_o); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag_o && !ovr_clr_i) |=> ovr_flag_o); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_i == 2'b11) |=> !req_o); // R4
endmodule

// File: tb/icap_channel_test.sv
module icap_channel_test;
  localparam int CW = 16;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          pin_i;
  logic [CW-1:0] cnt_i;
  logic [FW-1:0] filt_len_i;
  logic [1:0]    edge_sel_i;
  logic          rd_i, ovr_clr_i;
  logic [CW-1:0] cap_val_o;
  logic          cap_flag_o, ovr_flag_o, req_o;

  always #2 clk = ~clk;

  icap_channel #(.CNT_W(CW), .FLT_W(FW)) uut (.*);

  int nvec = 0, nerr = 0, ncyc = 0;
  bit done = 0;
  // pending stimulus
  bit p_rst, p_pin, p_rd, p_oclr;
  int p_n, p_sel;
  // reference model state
  bit m_s1, m_s2, m_acc, m_prv, m_flag, m_ovr, m_req;
  int m_run;
  logic [CW-1:0] m_cap, cnt_q;
  // observation
  int nreq;
  logic [CW-1:0] cap_a, cap_b;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, ncyc);
    end
  endtask

  task automatic step();
    bit hit, n_s1, n_s2, n_acc, n_prv, n_flag, n_ovr, n_req;
    int n_run, thr;
    logic [CW-1:0] n_cap;
    @(negedge clk);
    rst = p_rst; pin_i = p_pin; rd_i = p_rd; ovr_clr_i = p_oclr;
    filt_len_i = FW'(p_n); edge_sel_i = 2'(p_sel); cnt_i = cnt_q;
    if (p_rst) begin
      {n_s1, n_s2, n_acc, n_prv, n_flag, n_ovr, n_req} = '0;
      n_run = 0; n_cap = '0;
    end else begin
      case (p_sel)
        0: hit = m_acc && !m_prv;
        1: hit = !m_acc && m_prv;
        2: hit = m_acc != m_prv;
        default: hit = 0;
      endcase
      n_req = hit;
      n_cap = hit ? cnt_q : m_cap;
      n_flag = hit ? 1'b1 : (p_rd ? 1'b0 : m_flag);
      n_ovr = (hit && m_flag && !p_rd) ? 1'b1 : (p_oclr ? 1'b0 : m_ovr);
      n_prv = m_acc;
      n_acc = m_acc;
      thr = (p_n == 0) ? 1 : p_n;
      if (m_s2 == m_acc) n_run = 0;
      else if (m_run + 1 >= thr) begin n_acc = m_s2; n_run = 0; end
      else n_run = m_run + 1;
      n_s2 = m_s1; n_s1 = p_pin;
    end
    @(posedge clk);
    #1;
    ncyc++;
    cnt_q = cnt_q + 1'b1;
    m_s1 = n_s1; m_s2 = n_s2; m_acc = n_acc; m_prv = n_prv; m_run = n_run;
    m_flag = n_flag; m_ovr = n_ovr; m_req = n_req; m_cap = n_cap;
    chk("R5 cap_val", int'(cap_val_o), int'(m_cap));
    chk("R7 cap_flag", int'(cap_flag_o), int'(m_flag));
    chk("R8 ovr_flag", int'(ovr_flag_o), int'(m_ovr));
    chk("R6 req", int'(req_o), int'(m_req));
    if (req_o) begin nreq++; cap_a = cap_b; cap_b = cap_val_o; end
    p_rd = 0; p_oclr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // returns steps from the pin change until req_o is seen
  task automatic latency(input bit lvl, output int lat);
    int r0;
    r0 = nreq; lat = -1; p_pin = lvl;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (nreq != r0 && lat < 0) lat = i;
    end
  endtask

  task automatic clear_flags();
    p_rd = 1; p_oclr = 1; step();
  endtask

  initial begin
    int lat, r0;
    cnt_q = 16'h0100; nreq = 0; cap_a = '0; cap_b = '0;
    p_rst = 1; p_pin = 0; p_rd = 0; p_oclr = 0; p_n = 0; p_sel = 2;
    idle(3);
    chk("R1 reset cap_val", int'(cap_val_o), 0);
    chk("R1 reset flags", int'({cap_flag_o, ovr_flag_o, req_o}), 0);
    p_rst = 0; idle(4);

    // R2: latency with settings 0, 1 and 4
    latency(1, lat); chk("R2 latency N=0", lat, 4); clear_flags();
    p_n = 1; latency(0, lat); chk("R2 latency N=1", lat, 4); clear_flags();
    p_n = 4; latency(1, lat); chk("R2 latency N=4", lat, 7); clear_flags();
    p_pin = 0; idle(12); clear_flags();

    // R3: glitch one sample short of the window is dropped, a full one passes
    r0 = nreq; p_pin = 1; idle(3); p_pin = 0; idle(15);
    chk("R3 short glitch rejected", nreq - r0, 0);
    r0 = nreq; p_pin = 1; idle(4); p_pin = 0; idle(15);
    chk("R3 full-width pulse accepted", nreq - r0, 2);
    clear_flags();

    // R9: high time via both edges
    p_n = 2; p_sel = 2; p_pin = 1; idle(9); p_pin = 0; idle(12);
    chk("R9 high time", int'(cap_b - cap_a), 9);
    clear_flags();

    // R4: rising only, falling only, none
    p_sel = 0; r0 = nreq; p_pin = 1; idle(6); p_pin = 0; idle(10);
    chk("R4 rise only count", nreq - r0, 1); clear_flags();
    p_sel = 1; r0 = nreq; p_pin = 1; idle(6); p_pin = 0; idle(10);
    chk("R4 fall only count", nreq - r0, 1);
    chk("R4 fall captured", int'(cap_flag_o), 1); clear_flags();
    p_sel = 3; r0 = nreq; p_pin = 1; idle(6); p_pin = 0; idle(10);
    chk("R4 off no request", nreq - r0, 0);
    chk("R4 off flag unchanged", int'(cap_flag_o), 0);

    // R8: overcapture then clear; R7 read clears
    p_sel = 2; p_pin = 1; idle(8); p_pin = 0; idle(8);
    chk("R8 overcapture set", int'(ovr_flag_o), 1);
    p_rd = 1; step(); step();
    chk("R7 read clears flag", int'(cap_flag_o), 0);
    chk("R8 sticky after read", int'(ovr_flag_o), 1);
    p_oclr = 1; step(); step();
    chk("R8 cleared", int'(ovr_flag_o), 0);

    // random traffic, compared cycle by cycle against the model
    void'($urandom(32'h1CA7));
    for (int seg = 0; seg < 600; seg++) begin
      if ($urandom_range(0, 9) == 0) p_n = $urandom_range(0, 5);
      if ($urandom_range(0, 7) == 0) p_sel = $urandom_range(0, 3);
      p_pin = $urandom_range(0, 1);
      for (int k = $urandom_range(1, 8); k > 0; k--) begin
        p_rd = ($urandom_range(0, 5) == 0);
        p_oclr = ($urandom_range(0, 19) == 0);
        step();
      end
    end
    p_rst = 1; step(); p_rst = 0;
    chk("R1 reset after traffic", int'({cap_flag_o, ovr_flag_o, req_o}), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule